// File: doc/BRIEF.md
# Peripheral Clock Gate Controller with Access Wake

This block holds one 32-bit control word that decides which peripheral clock enables are active. Four auxiliary peripherals and the GPIO block each have a gate bit of their own, where 1 stops that clock. The GPIO gate bit also stops the divided clock that goes to the analog domain. A master "everything off" bit overrides all the individual gates.

The master bit is meant to be the last thing software writes before the system goes quiet. It clears itself when any peripheral register is touched, which the system signals on a single access strobe. It also clears itself when software reads the control word back. The clear acts in the same cycle as the access that causes it, so the peripheral being accessed gets its clock in time to finish the transaction.

A hibernate input keeps the analog-domain clock off whatever the GPIO gate bit holds. The register is a single location, reached through separate read and write strobes with no address. Read data is combinational and is zero when no read is in progress.

Top module: `pcg_top`

## Requirements
- R1: After reset the control word reads 0x0000001F: master bit (bit 5) clear, gate bits [4:0] set. All enable outputs are then low.
- R2: Bits [31:6] always read 0, and writing them has no effect on the value read back.
- R3: Bit i of [3:0] gates auxiliary enable i (1 means gated, so the enable is low). These bits are read/write and never change unless they are written.
- R4: Bit 4 gates both the GPIO enable and the analog-clock enable. It changes only by a write and is unaffected by any auto-clear.
- R5: While hibernate is high the analog-clock enable is low regardless of bit 4. Hibernate has no effect on the GPIO enable.
- R6: Once a write has set bit 5, every enable output is low from the next cycle on, until bit 5 is cleared.
- R7: A peripheral access strobe while bit 5 is set clears bit 5. In the strobe's own cycle the enables already follow the individual gate bits.
- R8: Reading the control word while bit 5 is set returns 0 in bit 5 and clears the bit. In that read cycle the enables already follow the individual gate bits.
- R9: A write that sets bit 5 in the same cycle as a peripheral access strobe leaves bit 5 cleared.
- R10: An auto-clear of bit 5 leaves bits [4:0] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data; zero when reg_rd is low |
| periph_access | input | 1 | High for one cycle on any peripheral register read or write |
| hibernate | input | 1 | High while the system is in hibernate |
| aux_clk_en | output | 4 | Clock enables of the four auxiliary peripherals |
| gpio_clk_en | output | 1 | GPIO clock enable |
| analog_clk_en | output | 1 | Enable of the divided clock to the analog domain |

## Verification
The bench checks that the enables return in the same cycle as the access strobe or the self-read. A design that cleared the master bit only at the next edge would starve the peripheral for the cycle of its access. It also checks that a self-read shows 0 in bit 5. A design that returned the stored bit would report the block asleep while waking it.

A write that sets the master bit in the same cycle as an access is checked to leave the bit clear. A design that let the write win would turn off the clocks just after the access. The bench also confirms that an auto-clear leaves the gate bits alone, and that hibernate cuts only the analog enable. A design that wired hibernate to the GPIO path, or that reset the gate bits on a wake, would show it at the enables.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    // Default geometry of the control word
    localparam int unsigned PCG_DATA_W  = 32;
    localparam int unsigned PCG_NUM_AUX = 4;

    // Per-cycle gating decision handed from the register to the enable logic
    typedef struct packed {
        logic master_off;   // effective master gate, already wake-adjusted
        logic gpio_off;     // GPIO / analog-clock gate
        logic hib;          // hibernate forces analog clock off
    } pcg_gate_t;

    // Reset image: every individual gate set, master clear
    function automatic logic [PCG_DATA_W-1:0] pcg_reset_word(input int unsigned n_aux);
        logic [PCG_DATA_W-1:0] w;
        w = '0;
        for (int unsigned i = 0; i <= n_aux; i++) w[i] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/pcg_ctl_reg.sv
module pcg_ctl_reg
    import pcg_pkg::*;
#(
    parameter int unsigned DATA_W  = PCG_DATA_W,
    parameter int unsigned NUM_AUX = PCG_NUM_AUX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               rd,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wake,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_AUX-1:0] aux_q,
    output logic               gpio_q,
    output logic               master_q,
    output logic               master_eff
);
    localparam int unsigned GPIO_BIT   = NUM_AUX;
    localparam int unsigned MASTER_BIT = NUM_AUX + 1;
    localparam int unsigned USED_W     = NUM_AUX + 2;

    logic clr_master;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:USED_W];

    // A peripheral access or a readback of this word wakes everything
    assign clr_master = wake | rd;
    assign master_eff = master_q & ~clr_master;

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_q    <= '1;
            gpio_q   <= 1'b1;
            master_q <= 1'b0;
        end else begin
            if (wr) begin
                aux_q  <= wdata[NUM_AUX-1:0];
                gpio_q <= wdata[GPIO_BIT];
            end
            if (clr_master)
                master_q <= 1'b0;
            else if (wr)
                master_q <= wdata[MASTER_BIT];
        end
    end

    always_comb begin
        logic [DATA_W-1:0] img;
        img                = '0;
        img[NUM_AUX-1:0]   = aux_q;
        img[GPIO_BIT]      = gpio_q;
        img[MASTER_BIT]    = master_eff;
        rdata              = rd ? img : '0;
    end

endmodule

// File: rtl/pcg_enable_gen.sv
module pcg_enable_gen
    import pcg_pkg::*;
#(
    parameter int unsigned NUM_AUX = PCG_NUM_AUX
) (
    input  pcg_gate_t          gate,
    input  logic [NUM_AUX-1:0] aux_off,
    output logic [NUM_AUX-1:0] aux_en,
    output logic               gpio_en,
    output logic               analog_en
);
    genvar g;
    generate
        for (g = 0; g < NUM_AUX; g++) begin : g_aux
            assign aux_en[g] = ~gate.master_off & ~aux_off[g];
        end
    endgenerate

    assign gpio_en   = ~gate.master_off & ~gate.gpio_off;
    assign analog_en = gpio_en & ~gate.hib;

endmodule

// File: rtl/pcg_top.sv
module pcg_top
    import pcg_pkg::*;
#(
    parameter int unsigned DATA_W  = PCG_DATA_W,
    parameter int unsigned NUM_AUX = PCG_NUM_AUX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               periph_access,
    input  logic               hibernate,
    output logic [NUM_AUX-1:0] aux_clk_en,
    output logic               gpio_clk_en,
    output logic               analog_clk_en
);
    logic [NUM_AUX-1:0] aux_q;
    logic               gpio_q;
    logic               master_q;
    logic               master_eff;
    pcg_gate_t          gate;

    pcg_ctl_reg #(.DATA_W(DATA_W), .NUM_AUX(NUM_AUX)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .wdata      (reg_wdata),
        .wake       (periph_access),
        .rdata      (reg_rdata),
        .aux_q      (aux_q),
        .gpio_q     (gpio_q),
        .master_q   (master_q),
        .master_eff (master_eff)
    );

    always_comb begin
        gate.master_off = master_eff;
        gate.gpio_off   = gpio_q;
        gate.hib        = hibernate;
    end

    pcg_enable_gen #(.NUM_AUX(NUM_AUX)) u_en (
        .gate      (gate),
        .aux_off   (aux_q),
        .aux_en    (aux_clk_en),
        .gpio_en   (gpio_clk_en),
        .analog_en (analog_clk_en)
    );

endmodule

// File: rtl/pcg_chk.sv
module pcg_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_AUX = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               periph_access,
    input logic               hibernate,
    input logic [NUM_AUX-1:0] aux_clk_en,
    input logic               gpio_clk_en,
    input logic               analog_clk_en,
    input logic [NUM_AUX-1:0] aux_q,
    input logic               gpio_q,
    input logic               master_q
);
    localparam int unsigned USED_W = NUM_AUX + 2;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:USED_W] == '0);

    // R3
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(aux_q));

    // R4
    gpio_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> $stable(gpio_q));

    // R5
    hib_analog_off_chk: assert property (@(posedge clk) disable iff (rst)
        hibernate |-> !analog_clk_en);

    // R6
    master_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        (master_q && !periph_access && !reg_rd) |-> (aux_clk_en == '0 && !gpio_clk_en && !analog_clk_en));

    // R7
    access_wake_now_chk: assert property (@(posedge clk) disable iff (rst)
        periph_access |-> (aux_clk_en == ~aux_q && gpio_clk_en == !gpio_q));

    // R8
    self_read_bit_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> !reg_rdata[NUM_AUX+1]);

    // R9
    access_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
        (periph_access || reg_rd) |=> !master_q);

    // R10
    wake_keeps_gates_chk: assert property (@(posedge clk) disable iff (rst)
        (master_q && periph_access && !reg_wr) |=> ($stable(aux_q) && $stable(gpio_q)));

    logic unused_chk;
    assign unused_chk = ^reg_wdata;

endmodule

bind pcg_top pcg_chk #(.DATA_W(DATA_W), .NUM_AUX(NUM_AUX)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .periph_access (periph_access),
    .hibernate     (hibernate),
    .aux_clk_en    (aux_clk_en),
    .gpio_clk_en   (gpio_clk_en),
    .analog_clk_en (analog_clk_en),
    .aux_q         (aux_q),
    .gpio_q        (gpio_q),
    .master_q      (master_q)
);

// File: tb/tb_pcg_top.sv
module tb_pcg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_access = 1'b0;
    logic        hibernate = 1'b0;
    logic [3:0]  aux_clk_en;
    logic        gpio_clk_en;
    logic        analog_clk_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcg_top dut (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .periph_access (periph_access),
        .hibernate     (hibernate),
        .aux_clk_en    (aux_clk_en),
        .gpio_clk_en   (gpio_clk_en),
        .analog_clk_en (analog_clk_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // enables packed as {analog, gpio, aux[3:0]}
    function automatic logic [31:0] ens();
        return {26'd0, analog_clk_en, gpio_clk_en, aux_clk_en};
    endfunction

    // drive inputs after the falling edge, let them act at the next rising edge
    task automatic write_reg(input logic [31:0] v, input logic acc);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v; periph_access = acc;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; periph_access = 1'b0;
    endtask

    // read the register in the current cycle, returning data sampled before the edge
    task automatic read_reg(output logic [31:0] v, output logic [31:0] en_now);
        @(negedge clk);
        reg_rd = 1'b1;
        #2;
        v = reg_rdata; en_now = ens();
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v, e;
        check("R1 enables after reset", ens(), 32'h0);
        read_reg(v, e);
        check("R1 reset word", v, 32'h0000_001F);
    endtask

    task automatic t_aux_and_reserved();
        logic [31:0] v, e;
        write_reg(32'h0000_000A, 1'b0);
        #2;
        check("R3 aux enables follow gates", ens(), 32'h35);
        read_reg(v, e);
        check("R3 readback", v, 32'h0000_000A);
        write_reg(32'hFFFF_FFC5, 1'b0);
        read_reg(v, e);
        check("R2 reserved bits read zero", v, 32'h0000_0005);
    endtask

    task automatic t_hibernate();
        @(negedge clk); hibernate = 1'b1; #2;
        check("R5 hibernate kills analog only", ens(), 32'h1A);
        write_reg(32'h0000_0010, 1'b0); #2;
        check("R5 hibernate with gpio gated", ens(), 32'h0F);
        @(negedge clk); hibernate = 1'b0;
        write_reg(32'h0000_0005, 1'b0);
    endtask

    task automatic t_wake_access(input string kind);
        logic [31:0] v, e;
        write_reg(32'h0000_0025, 1'b0); #2;
        check("R6 master gates all", ens(), 32'h0);
        @(negedge clk); #2;
        check("R6 master still gating", ens(), 32'h0);
        periph_access = 1'b1; #2;
        check({"R7 enables in strobe cycle ", kind}, ens(), 32'h3A);
        @(negedge clk); periph_access = 1'b0; #2;
        check({"R7 stays awake after ", kind}, ens(), 32'h3A);
        read_reg(v, e);
        check("R10 gates kept after wake", v, 32'h0000_0005);
    endtask

    task automatic t_self_read();
        logic [31:0] v, e;
        write_reg(32'h0000_0023, 1'b0); #2;
        check("R6 master set before self-read", ens(), 32'h0);
        read_reg(v, e);
        check("R8 self-read bit5 zero", v, 32'h0000_0003);
        check("R8 enables in read cycle", e, 32'h3C);
        #2;
        check("R8 awake after self-read", ens(), 32'h3C);
    endtask

    task automatic t_coincident();
        write_reg(32'h0000_0020, 1'b1); #2;
        check("R9 access beats write", ens(), 32'h3F);
    endtask

    task automatic t_sticky();
        logic [31:0] v, e;
        write_reg(32'h0000_0030, 1'b0);
        @(negedge clk); periph_access = 1'b1;
        @(negedge clk); periph_access = 1'b0; #2;
        check("R4 gpio gate survives wake", ens(), 32'h0F);
        read_reg(v, e);
        check("R4 bit4 still set", v, 32'h0000_0010);
        write_reg(32'h0000_0000, 1'b0); #2;
        check("R4 cleared only by write", ens(), 32'h3F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        t_reset();
        t_aux_and_reserved();
        t_hibernate();
        t_wake_access("read");
        t_wake_access("write");
        t_self_read();
        t_coincident();
        t_sticky();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule